// File: doc/BRIEF.md
# Burst-Length Wake-Up Code Detector

This block keeps an active tag asleep until a reader sends a particular rhythm of RF energy. A passive front end gives one bit that is high while RF energy is present. The detector resynchronises that bit to a slow system clock of roughly 100 kHz. It times each high run in clock ticks and compares four runs in a row against four programmed lengths. It raises `wake` only when all four match in order. Random energy from noise or from other readers does not match the rhythm, so the active receiver and the controller stay powered down.

Each burst is timed from its rising edge to its falling edge. The counter stops at its all-ones value and does not wrap. A measured length is accepted when it lies within a fixed tolerance of the expected symbol. A rejected burst produces a one-cycle `mismatch` pulse and restarts the search. The rejected burst still counts as a first symbol if it fits symbol zero. If the silence after a burst runs longer than `gap_limit`, a partial sequence is dropped. Once `wake` is set, it stays set until `clear` is pulsed.

Top module: `burst_wake_detector`

## Requirements
- R1: After reset, `wake` and `mismatch` are both low.
- R2: Four bursts whose lengths match `code_sym0`, `code_sym1`, `code_sym2` and `code_sym3` in that order set `wake` within four clock cycles of the fourth burst's falling edge. The example code used by the bench is 2, 12, 3, 9.
- R3: A burst matches when its length differs from the expected symbol by at most TOL ticks (default 1). A difference of TOL+1 or more is rejected.
- R4: Every rejected burst raises `mismatch` for exactly one clock cycle and restarts the sequence.
- R5: A rejected burst whose length fits `code_sym0` counts as the first symbol of a new sequence.
- R6: While a sequence is partly matched, a low time of more than `gap_limit` ticks discards it. A `gap_limit` of 0 turns the timeout off.
- R7: `wake` stays high through any later bursts until `clear` is high at a clock edge. `clear` drops `wake` and restarts the sequence.
- R8: The length counter saturates at 2^CNT_W-1. With CNT_W=8, a burst of 300 ticks is measured as 255.
- R9: The same four lengths sent in a different order do not set `wake`.
- R10: A single stray burst, or an incomplete sequence, never sets `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock (about 100 kHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_in | input | 1 | Asynchronous RF-energy-present level from the passive front end |
| clear | input | 1 | Drops `wake` and restarts the sequence |
| code_sym0 | input | CNT_W | First expected burst length in ticks |
| code_sym1 | input | CNT_W | Second expected burst length |
| code_sym2 | input | CNT_W | Third expected burst length |
| code_sym3 | input | CNT_W | Fourth expected burst length |
| gap_limit | input | CNT_W | Maximum low time between bursts; 0 disables the timeout |
| wake | output | 1 | Sticky wake request for the active receiver |
| mismatch | output | 1 | One-cycle pulse for a rejected burst |

## Verification
A sequence index that sits in the wrong state shows up at the ports on the next burst's falling edge, two synchroniser cycles plus one register later. It appears either as a missing or early `wake`, or as a `mismatch` pulse where none belongs. A length counter that wraps or drifts produces the same effect: a saturated long burst fails to match or a short one wrongly matches. A timeout counter that restarts at the wrong time is visible only when the delayed final symbol arrives. The bench therefore checks `wake` a few cycles after each last burst and counts `mismatch` pulses across each window.

// File: rtl/bwd_pkg.sv
// Shared constants and helpers for the burst wake detector.
// Assumes lengths fit in 32 bits (CNT_W <= 32).
package bwd_pkg;
    localparam int SYMBOLS = 4;
    localparam int IDX_W   = $clog2(SYMBOLS);

    typedef logic [IDX_W-1:0] sym_idx_t;

    // True when a and b differ by no more than tol.
    function automatic logic within_tol(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [31:0] tol);
        logic [31:0] diff;
        diff = (a > b) ? (a - b) : (b - a);
        return diff <= tol;
    endfunction
endpackage

// File: rtl/bwd_sync.sv
// Multi-flop synchroniser for the asynchronous burst level.
// Assumes STAGES >= 2; output lags the input by STAGES clocks.
module bwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bwd_len_meter.sv
// Times high runs and low runs of the synchronised burst level.
// len_q holds the number of high cycles so far (saturating). done marks
// the first low cycle after a burst, while len_q still holds its length.
// gap_over is set after more than gap_limit low cycles (0 disables it).
module bwd_len_meter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic [CNT_W-1:0] gap_limit,
    output logic             lvl_prev,
    output logic [CNT_W-1:0] len_q,
    output logic             done,
    output logic             gap_over
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] gap_q;

    // Delay the level one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl;
    end

    // Burst length: restart on a rising edge, then count up without wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)                  len_q <= '0;
        else if (lvl && !lvl_prev)   len_q <= CNT_W'(1);
        else if (lvl && len_q != CNT_MAX) len_q <= len_q + 1'b1;
    end

    // Gap length: held at zero while high, counts low cycles without wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gap_q <= '0;
        else if (lvl)               gap_q <= '0;
        else if (gap_q != CNT_MAX)  gap_q <= gap_q + 1'b1;
    end

    assign done     = !lvl && lvl_prev;
    assign gap_over = !lvl && (gap_limit != '0) && (gap_q >= gap_limit);
endmodule

// File: rtl/bwd_seq_matcher.sv
// Tracks how many code symbols have matched and drives wake / mismatch.
// Assumes done is a single-cycle event and len is valid while done is high.
module bwd_seq_matcher #(
    parameter int CNT_W = 8,
    parameter int TOL   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             done,
    input  logic             gap_over,
    input  logic [CNT_W-1:0] len,
    input  logic [CNT_W-1:0] code [bwd_pkg::SYMBOLS],
    output logic             wake,
    output logic             mismatch,
    output bwd_pkg::sym_idx_t idx
);
    import bwd_pkg::*;

    localparam sym_idx_t LAST = sym_idx_t'(SYMBOLS - 1);

    logic hit_expected;
    logic hit_first;

    // Compare the finished burst with the expected and the first symbol.
    always_comb begin
        hit_expected = within_tol(32'(len), 32'(code[idx]), 32'(TOL));
        hit_first    = within_tol(32'(len), 32'(code[0]),   32'(TOL));
    end

    // Advance, restart or complete the sequence; hold wake until clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            wake     <= 1'b0;
            mismatch <= 1'b0;
        end else begin
            mismatch <= 1'b0;
            if (clear) begin
                idx  <= '0;
                wake <= 1'b0;
            end else if (done) begin
                if (hit_expected) begin
                    if (idx == LAST) begin
                        wake <= 1'b1;
                        idx  <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end else begin
                    mismatch <= 1'b1;
                    idx      <= hit_first ? sym_idx_t'(1) : '0;
                end
            end else if (gap_over) begin
                idx <= '0;
            end
        end
    end
endmodule

// File: rtl/burst_wake_detector.sv
// Top level: synchroniser, burst timer and sequence matcher.
// Assumes CNT_W is one of 2, 4, 8, 16 or 32 and clk is the slow tick clock.
module burst_wake_detector #(
    parameter int CNT_W       = 8,
    parameter int TOL         = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_in,
    input  logic             clear,
    input  logic [CNT_W-1:0] code_sym0,
    input  logic [CNT_W-1:0] code_sym1,
    input  logic [CNT_W-1:0] code_sym2,
    input  logic [CNT_W-1:0] code_sym3,
    input  logic [CNT_W-1:0] gap_limit,
    output logic             wake,
    output logic             mismatch
);
    import bwd_pkg::*;

    logic             sync_lvl;
    logic             sync_prev;
    logic [CNT_W-1:0] burst_len;
    logic             evt_done;
    logic             evt_gap;
    sym_idx_t         seq_idx;
    logic [CNT_W-1:0] code_arr [SYMBOLS];

    // Gather the programmed symbols into an indexable array.
    always_comb begin
        code_arr[0] = code_sym0;
        code_arr[1] = code_sym1;
        code_arr[2] = code_sym2;
        code_arr[3] = code_sym3;
    end

    bwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (burst_in),
        .q_sync  (sync_lvl)
    );

    bwd_len_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (sync_lvl),
        .gap_limit (gap_limit),
        .lvl_prev  (sync_prev),
        .len_q     (burst_len),
        .done      (evt_done),
        .gap_over  (evt_gap)
    );

    bwd_seq_matcher #(.CNT_W(CNT_W), .TOL(TOL)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .done     (evt_done),
        .gap_over (evt_gap),
        .len      (burst_len),
        .code     (code_arr),
        .wake     (wake),
        .mismatch (mismatch),
        .idx      (seq_idx)
    );
endmodule

// File: rtl/bwd_checker.sv
// Temporal checks on the burst wake detector, attached by bind.
module bwd_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             wake,
    input logic             mismatch,
    input logic             evt_done,
    input logic             sync_lvl,
    input logic             sync_prev,
    input logic [CNT_W-1:0] burst_len
);
    // R1: outputs quiet on the first cycle out of reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!wake && !mismatch));

    // R2: wake can only rise right after a burst has finished.
    assert_wake_after_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(evt_done));

    // R4: a mismatch follows a finished burst and lasts one cycle.
    assert_mismatch_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> $past(evt_done));
    assert_mismatch_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> !mismatch);

    // R7: wake is sticky without clear, and clear drops it.
    assert_wake_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !clear) |=> wake);
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !wake);

    // R8: inside a burst the length never goes down (no wrap).
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lvl && sync_prev) |=> (burst_len >= $past(burst_len)));
endmodule

bind burst_wake_detector bwd_checker #(.CNT_W(CNT_W)) u_bwd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .wake      (wake),
    .mismatch  (mismatch),
    .evt_done  (evt_done),
    .sync_lvl  (sync_lvl),
    .sync_prev (sync_prev),
    .burst_len (burst_len)
);

// File: tb/burst_wake_detector_bench.sv
// Self-checking bench: table of four-burst patterns, then directed cases.
module burst_wake_detector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int GAP = 4;
    localparam int NVEC = 7;
    // Each row: four burst lengths, expected wake.
    localparam int unsigned VEC [NVEC][5] = '{
        '{2, 12, 3, 9, 1},   // R2 exact code
        '{3, 11, 4, 10, 1},  // R3 all +/-1
        '{1, 13, 2, 8, 1},   // R3 other side
        '{2, 12, 3, 11, 0},  // R3 off by 2
        '{12, 2, 9, 3, 0},   // R9 wrong order
        '{2, 12, 5, 9, 0},   // R4 bad third symbol
        '{2, 2, 12, 3, 0}    // R5 incomplete after restart
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         burst_in = 1'b0;
    logic         clear = 1'b0;
    logic [W-1:0] code_sym0 = 8'd2;
    logic [W-1:0] code_sym1 = 8'd12;
    logic [W-1:0] code_sym2 = 8'd3;
    logic [W-1:0] code_sym3 = 8'd9;
    logic [W-1:0] gap_limit = 8'd20;
    logic         wake;
    logic         mismatch;

    int checks = 0;
    int errors = 0;
    int mm_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_wake_detector #(.CNT_W(W)) u_burst_wake_detector (
        .clk(clk), .rst_n(rst_n), .burst_in(burst_in), .clear(clear),
        .code_sym0(code_sym0), .code_sym1(code_sym1),
        .code_sym2(code_sym2), .code_sym3(code_sym3),
        .gap_limit(gap_limit), .wake(wake), .mismatch(mismatch)
    );

    // Count mismatch cycles, sampled away from the active edge.
    always @(negedge clk) if (mismatch) mm_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic burst(input int len, input int gap);
        burst_in = 1'b1;
        repeat (len) @(negedge clk);
        burst_in = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 wake", int'(wake), 0);
        check("R1 mismatch", int'(mismatch), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wake after release", int'(wake), 0);

        // Table walk: each row from a clean sequence state.
        for (int v = 0; v < NVEC; v++) begin
            do_clear();
            for (int s = 0; s < 4; s++) burst(int'(VEC[v][s]), GAP);
            repeat (2) @(negedge clk);
            check($sformatf("R2/R3/R9 row %0d", v), int'(wake), int'(VEC[v][4]));
        end

        // R4: one bad burst gives exactly one mismatch pulse.
        do_clear();
        mm_cnt = 0;
        burst(7, 8);
        check("R4 mismatch pulses", mm_cnt, 1);
        check("R10 stray burst no wake", int'(wake), 0);

        // R4: mismatch mid-sequence restarts; code afterwards still wakes.
        do_clear();
        mm_cnt = 0;
        burst(2, GAP); burst(12, GAP); burst(6, GAP);
        burst(2, GAP); burst(12, GAP); burst(3, GAP); burst(9, 8);
        check("R4 restart mismatch count", mm_cnt, 1);
        check("R4 wake after restart", int'(wake), 1);

        // R5: rejected burst that fits symbol 0 starts a new sequence.
        do_clear();
        burst(2, GAP); burst(2, GAP); burst(12, GAP); burst(3, GAP); burst(9, 8);
        check("R5 reused first symbol", int'(wake), 1);

        // R6: long gap before the last symbol discards the sequence.
        do_clear();
        burst(2, GAP); burst(12, GAP); burst(3, 40); burst(9, 8);
        check("R6 timeout discards", int'(wake), 0);

        // R6: gap_limit of 0 disables the timeout.
        gap_limit = '0;
        do_clear();
        burst(2, GAP); burst(12, GAP); burst(3, 40); burst(9, 8);
        check("R6 timeout disabled", int'(wake), 1);
        gap_limit = 8'd20;

        // R7: wake holds through noise bursts, clear drops it.
        burst(5, GAP); burst(30, 10);
        check("R7 wake sticky", int'(wake), 1);
        do_clear();
        check("R7 clear drops wake", int'(wake), 0);

        // R8: saturated length matches a symbol of 255.
        code_sym3 = 8'd255;
        do_clear();
        burst(2, GAP); burst(12, GAP); burst(3, GAP); burst(300, 8);
        check("R8 saturated length matches", int'(wake), 1);
        do_clear();
        burst(2, GAP); burst(12, GAP); burst(3, GAP); burst(253, 8);
        check("R8 253 vs 255 rejected", int'(wake), 0);
        code_sym3 = 8'd9;

        // R10: incomplete sequence leaves wake low.
        do_clear();
        burst(2, GAP); burst(12, GAP); burst(3, 30);
        check("R10 incomplete no wake", int'(wake), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule